// File: doc/BRIEF.md
# Set/Clear Interrupt Flag Register with Pin Driver

This block gathers seven hardware event sources into one 8-bit flag register. The sources are transmit done, receive done, idle, FIFO high alert, FIFO low alert, error and timer expiry. A flag set by an event stays set until software removes it. Software reaches the flags through a small register port, and each write either sets or clears bits. Bit 7 of the written word chooses the action, and bits 6..0 mark the bits it applies to. This differs from the common write-one-to-clear scheme: software can raise a flag as easily as it can drop one.

A second register holds one enable per flag, plus an inversion bit for the pin. A third register holds the drive-mode bit. Each flag is ANDed with its enable, and the results are ORed into one request. The request, inverted when the inversion bit is set, forms the pin level. In push-pull mode that level is always driven. Otherwise the pin is driven low only when its level is 0 and is released (high impedance) when its level is 1, which suits a shared open-drain line. The event producers and the host bus protocol lie outside this block.

Top module: `irq_setclr_top`

## Requirements
- R1: After reset the flag register reads 14h, the enable register reads 80h, the drive-mode register reads 00h, and `irq_oe` is 0.
- R2: A write to address 1 with bit 7 = 1 sets every flag whose bit in 6..0 is 1 and leaves the other flags unchanged.
- R3: A write to address 1 with bit 7 = 0 clears every flag whose bit in 6..0 is 1 and leaves the other flags unchanged.
- R4: An event pulse sets its flag on the next clock edge. The flag positions are: tx done bit 6, rx done bit 5, idle bit 4, FIFO high bit 3, FIFO low bit 2, timer bit 0. Bit 1 is set in every cycle in which any bit of `err_bits` is 1.
- R5: Flags are cleared only by a software clear write. A flag stays set after its event or alert condition goes away.
- R6: When an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R7: Read address 0 returns the enable register, address 1 returns the flags with bit 7 always 0, address 2 returns the drive-mode bit in bit 7 with the other bits 0, and address 3 returns 00h.
- R8: The request is the OR over bits 6..0 of (flag AND enable). The pin level is the request XOR enable bit 7 (the inversion bit).
- R9: When drive-mode bit 7 is 1, `irq_oe` is 1 and `irq_o` equals the pin level.
- R10: When drive-mode bit 7 is 0, `irq_oe` is the inverse of the pin level and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 enable, 1 flags, 2 drive mode |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| ev_tx | input | 1 | Transmit done pulse |
| ev_rx | input | 1 | Receive done pulse |
| ev_idle | input | 1 | Command idle pulse |
| ev_hi_alert | input | 1 | FIFO high alert |
| ev_lo_alert | input | 1 | FIFO low alert |
| ev_tmr | input | 1 | Timer reached zero |
| err_bits | input | ERR_W | Error status bits |
| irq_o | output | 1 | Pin output value |
| irq_oe | output | 1 | Pin output enable |

## Verification
Two functions can act on the same flag in the same cycle: a hardware event and a software clear. The bench provokes this in two ways. It drives an event pulse together with a clear write whose mask covers that bit. It also holds an error bit high while software clears flag 1. It then judges the outcome by reading the flag back on the next cycle and expecting the bit set. A long mixed sequence of writes and events also produces such overlaps at random. There, each read and each pin value is compared against a model in the bench that applies the set, clear and event terms in the required order.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int NSRC   = 7;

    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd1;
    localparam logic [ADDR_W-1:0] A_DRIVE  = 2'd2;
    localparam logic [ADDR_W-1:0] A_NONE   = 2'd3;

    localparam int B_TMR  = 0;
    localparam int B_ERR  = 1;
    localparam int B_LO   = 2;
    localparam int B_HI   = 3;
    localparam int B_IDLE = 4;
    localparam int B_RX   = 5;
    localparam int B_TX   = 6;
    localparam int B_MODE = 7;

    localparam logic [DATA_W-1:0] FLAG_RST  = 8'h14;
    localparam logic [DATA_W-1:0] EN_RST    = 8'h80;
    localparam logic [DATA_W-1:0] DRIVE_RST = 8'h00;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_flag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NSRC-1:0]   hw_set,
    output logic [NSRC-1:0]   flags
);
    logic [NSRC-1:0] sw_set, sw_clr, flags_nxt;

    always_comb begin
        sw_set = (wr_flag &&  wr_data[B_MODE]) ? wr_data[NSRC-1:0] : '0;
        sw_clr = (wr_flag && !wr_data[B_MODE]) ? wr_data[NSRC-1:0] : '0;
        flags_nxt = (flags & ~sw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= FLAG_RST[NSRC-1:0];
        else        flags <= flags_nxt;
    end

    // R5
    only_sw_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags) & ~flags)) |-> $past(wr_flag && !wr_data[B_MODE]));
    // R4
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set)));
    // R2
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && wr_data[B_MODE]) |=> ((flags & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] enable_q,
    output logic              push_pull
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= EN_RST;
            push_pull <= DRIVE_RST[B_MODE];
        end else if (wr_en) begin
            if (wr_addr == A_ENABLE) enable_q  <= wr_data;
            if (wr_addr == A_DRIVE)  push_pull <= wr_data[B_MODE];
        end
    end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   flags,
    input  logic [DATA_W-1:0] enable_q,
    input  logic              push_pull,
    output logic              irq_o,
    output logic              irq_oe
);
    logic req, level;

    always_comb begin
        req   = |(flags & enable_q[NSRC-1:0]);
        level = req ^ enable_q[B_MODE];
        if (push_pull) begin
            irq_oe = 1'b1;
            irq_o  = level;
        end else begin
            irq_oe = ~level;
            irq_o  = 1'b0;
        end
    end

    // R9
    push_pull_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> irq_oe);
    // R10
    open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && irq_oe) |-> !irq_o);
endmodule

// File: rtl/irq_setclr_top.sv
module irq_setclr_top
    import irq_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic              ev_tx,
    input  logic              ev_rx,
    input  logic              ev_idle,
    input  logic              ev_hi_alert,
    input  logic              ev_lo_alert,
    input  logic              ev_tmr,
    input  logic [ERR_W-1:0]  err_bits,
    output logic              irq_o,
    output logic              irq_oe
);
    logic [NSRC-1:0]   hw_set, flags;
    logic [DATA_W-1:0] enable_q;
    logic              push_pull;
    logic              wr_flag;

    always_comb begin
        hw_set         = '0;
        hw_set[B_TX]   = ev_tx;
        hw_set[B_RX]   = ev_rx;
        hw_set[B_IDLE] = ev_idle;
        hw_set[B_HI]   = ev_hi_alert;
        hw_set[B_LO]   = ev_lo_alert;
        hw_set[B_ERR]  = |err_bits;
        hw_set[B_TMR]  = ev_tmr;
        wr_flag        = wr_en && (wr_addr == A_FLAGS);
    end

    irq_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .wr_flag(wr_flag), .wr_data(wr_data),
        .hw_set(hw_set), .flags(flags)
    );

    irq_ctl_regs u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .enable_q(enable_q), .push_pull(push_pull)
    );

    irq_pin_drv u_pin (
        .clk(clk), .rst_n(rst_n), .flags(flags), .enable_q(enable_q),
        .push_pull(push_pull), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    always_comb begin
        unique case (rd_addr)
            A_ENABLE: rd_data = enable_q;
            A_FLAGS:  rd_data = {1'b0, flags};
            A_DRIVE:  rd_data = {push_pull, 7'b0};
            A_NONE:   rd_data = '0;
            default:  rd_data = '0;
        endcase
    end

    // R7
    flag_read_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_FLAGS) |-> !rd_data[B_MODE]);
endmodule

// File: tb/sim_irq_setclr_top.sv
module sim_irq_setclr_top;
    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic ev_tx = 0, ev_rx = 0, ev_idle = 0, ev_hi_alert = 0, ev_lo_alert = 0, ev_tmr = 0;
    logic [7:0] err_bits = 0;
    logic irq_o, irq_oe;

    int total = 0, bad = 0;
    logic [6:0] m_flags;
    logic [7:0] m_en;
    logic       m_pp;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    irq_setclr_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ev_tx(ev_tx), .ev_rx(ev_rx),
        .ev_idle(ev_idle), .ev_hi_alert(ev_hi_alert), .ev_lo_alert(ev_lo_alert),
        .ev_tmr(ev_tmr), .err_bits(err_bits), .irq_o(irq_o), .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // ev bits: 6 tx, 5 rx, 4 idle, 3 hi, 2 lo, 0 tmr (bit 1 unused, err via err)
    task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d,
                       input logic [6:0] ev, input logic [7:0] err);
        logic [6:0] setm, clrm, evm;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        ev_tx = ev[6]; ev_rx = ev[5]; ev_idle = ev[4];
        ev_hi_alert = ev[3]; ev_lo_alert = ev[2]; ev_tmr = ev[0];
        err_bits = err;
        setm = (we && a == 2'd1 && d[7])  ? d[6:0] : 7'h0;
        clrm = (we && a == 2'd1 && !d[7]) ? d[6:0] : 7'h0;
        evm  = {ev[6:2], (err != 0), ev[0]};
        m_flags = (m_flags & ~clrm) | setm | evm;
        if (we && a == 2'd0) m_en = d;
        if (we && a == 2'd2) m_pp = d[7];
        @(posedge clk);
        #1;
        wr_en = 0; ev_tx = 0; ev_rx = 0; ev_idle = 0; ev_hi_alert = 0;
        ev_lo_alert = 0; ev_tmr = 0; err_bits = 0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic pin_chk();
        logic req, lvl;
        req = |(m_flags & m_en[6:0]);
        lvl = req ^ m_en[7];
        if (m_pp) begin
            chk("R9 oe", {7'b0, irq_oe}, 8'h01);
            chk("R8/R9 level", {7'b0, irq_o}, {7'b0, lvl});
        end else begin
            chk("R10 oe", {7'b0, irq_oe}, {7'b0, ~lvl});
            chk("R10 out", {7'b0, irq_o}, 8'h00);
        end
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_flags = 7'h14; m_en = 8'h80; m_pp = 0;
        #23 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 flags", 2'd1, 8'h14);
        rd_chk("R1 enable", 2'd0, 8'h80);
        rd_chk("R1 drive", 2'd2, 8'h00);
        chk("R1 oe", {7'b0, irq_oe}, 8'h00);
        rd_chk("R7 addr3", 2'd3, 8'h00);
        // R2 set all, bit7 reads 0 (R7)
        cyc(1, 2'd1, 8'hFF, 7'h0, 8'h0);
        rd_chk("R2/R7 set all", 2'd1, 8'h7F);
        // R3 clear pattern
        cyc(1, 2'd1, 8'h55, 7'h0, 8'h0);
        rd_chk("R3 clear 55", 2'd1, 8'h2A);
        cyc(1, 2'd1, 8'h7F, 7'h0, 8'h0);
        rd_chk("R3 clear all", 2'd1, 8'h00);
        cyc(1, 2'd1, 8'h81, 7'h0, 8'h0);
        rd_chk("R2 set bit0 only", 2'd1, 8'h01);
        cyc(1, 2'd1, 8'h01, 7'h0, 8'h0);
        // R4 each event source alone
        for (int b = 0; b < 7; b++) begin
            if (b == 1) cyc(0, 2'd0, 8'h0, 7'h0, 8'h40);
            else        cyc(0, 2'd0, 8'h0, 7'(1 << b), 8'h0);
            rd_chk("R4 event position", 2'd1, 8'(1 << b));
            // R5 stays set after the source goes away
            cyc(0, 2'd0, 8'h0, 7'h0, 8'h0);
            rd_chk("R5 latched", 2'd1, 8'(1 << b));
            cyc(1, 2'd1, 8'h7F, 7'h0, 8'h0);
        end
        // R6 event beats clear
        cyc(1, 2'd1, 8'h7F, 7'h40, 8'h0);
        rd_chk("R6 tx vs clear", 2'd1, 8'h40);
        cyc(1, 2'd1, 8'h7F, 7'h0, 8'h03);
        rd_chk("R6 err vs clear", 2'd1, 8'h02);
        // R8 R9 R10 sweep over enables, inversion, mode
        for (int mode = 0; mode < 2; mode++) begin
            cyc(1, 2'd2, mode[0] ? 8'h80 : 8'h00, 7'h0, 8'h0);
            rd_chk("R7 drive read", 2'd2, mode[0] ? 8'h80 : 8'h00);
            for (int e = 0; e < 256; e += 5) begin
                cyc(1, 2'd0, 8'(e), 7'h0, 8'h0);
                rd_chk("R7 enable read", 2'd0, 8'(e));
                pin_chk();
                cyc(1, 2'd1, 8'h80 | 8'(e * 3), 7'h0, 8'h0);
                pin_chk();
                cyc(1, 2'd1, 8'h7F, 7'h0, 8'h0);
                pin_chk();
            end
        end
        // mixed random sequence
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] a;
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = (seed[25:24] == 2'd3) ? 2'd1 : seed[25:24];
            cyc(seed[31], a, seed[23:16], seed[14:8] & seed[6:0], seed[15] ? 8'h0 : {7'b0, seed[7]});
            rd_chk("R2/R3/R4/R6 mixed flags", 2'd1, {1'b0, m_flags});
            pin_chk();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule